// File: doc/BRIEF.md
# Mixed-Precision Issue-Driven Multiply Sequencer

This block is a multiply pipeline that moves only when a new operation is issued into it. Each accepted issue carries two unsigned operands and a precision flag, either single or double. In the same cycle, the issue hands back the oldest finished product. Single-precision operations pass through three stage slots. Double-precision operations finish after two slots, and each one blocks the issue port for the cycle after it enters. The product itself is a plain unsigned integer multiply, so the work of the block is sequencing: when a result becomes available, in what order results leave, and which in-flight result is lost when the precision changes.

A client that wants a result must keep issuing operations. Dummy operations are enough to flush the pipeline. On a cycle with no accepted issue the block returns nothing, and the pipeline contents stay where they are. When the precision flag of an accepted issue differs from the flag of the issue before it, the operation issued two issues earlier is dropped. That slot then reads as empty when it would have been returned.

Top module: `mpx_mul_seq`

## Requirements
- R1: While reset is asserted and after it is released, `issue_ready` is high and the pipeline is empty. The first accepted issues after reset return `res_valid` low.
- R2: With all-single traffic, the product `op_a*op_b` of an operation is returned, with `res_valid` high, by the third accepted issue after its own.
- R3: With all-double traffic, the product of an operation is returned by the second accepted issue after its own. Double issues on every second cycle return the first product at the third issue.
- R4: In the cycle after an accepted double issue (`issue_dbl`=1), `issue_ready` is low, and an `issue_valid` pulse in that cycle is ignored. In every other cycle `issue_ready` is high.
- R5: On any cycle without an accepted issue, `res_valid` is low, and the pipeline contents do not move.
- R6: When an accepted issue has a precision different from the accepted issue just before it, the operation issued two accepted issues earlier is discarded and is never returned.
- R7: An issue that meets an empty or discarded slot at the exit returns `res_valid` low and `res_data` zero.
- R8: Products leave in the order the operations were issued, across precision changes, with discarded ones skipped.
- R9: Asserting `rst_n` low in the middle of traffic empties every slot. No operation issued before the reset is returned after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Request to issue an operation |
| issue_dbl | input | 1 | Precision of the operation: 1 double, 0 single |
| op_a | input | 32 | First unsigned operand |
| op_b | input | 32 | Second unsigned operand |
| issue_ready | output | 1 | Issue is accepted this cycle when high |
| res_valid | output | 1 | A product is returned in this issue cycle |
| res_data | output | 64 | Returned product, zero when not valid |

## Verification
The assertions assume that `issue_valid` is only treated as accepted together with `issue_ready`. They also assume that the operands and the precision flag are stable for the whole cycle in which they are sampled. The stimulus drives every input on the falling edge, holds it until the next falling edge, and samples the combinational result between those edges. Some issue attempts fall on the stall cycle after a double on purpose, so the ignored-request path is exercised. A reference model in the bench follows the slot rules of R2 to R8 and predicts every returned product and every discard from the issue order alone.

// File: rtl/mpx_mul_pkg.sv
package mpx_mul_pkg;
  localparam int unsigned OP_W    = 32;
  localparam int unsigned RES_W   = 2 * OP_W;
  localparam int unsigned NSLOT   = 3;
  localparam int unsigned DBL_END = 1;   // index of the slot where doubles finish
  localparam int unsigned SGL_END = NSLOT - 1;

  typedef struct packed {
    logic             vld;
    logic             dbl;
    logic [RES_W-1:0] prod;
  } slot_t;
endpackage

// File: rtl/mpx_issue_ctrl.sv
module mpx_issue_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_valid,
  input  logic issue_dbl,
  output logic issue_ready,
  output logic fire,
  output logic prec_switch
);
  logic stall_q, stall_d;
  logic last_dbl_q, last_dbl_d;
  logic seen_q, seen_d;

  assign issue_ready = ~stall_q;
  assign fire        = issue_valid & ~stall_q;
  assign prec_switch = fire & seen_q & (issue_dbl != last_dbl_q);

  always_comb begin
    stall_d    = fire & issue_dbl;
    last_dbl_d = last_dbl_q;
    seen_d     = seen_q;
    if (fire) begin
      last_dbl_d = issue_dbl;
      seen_d     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q    <= 1'b0;
      last_dbl_q <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      stall_q    <= stall_d;
      last_dbl_q <= last_dbl_d;
      seen_q     <= seen_d;
    end
  end

  p_stall_after_dbl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && issue_dbl) |=> !issue_ready);
  p_stall_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_ready |=> issue_ready);
  p_ready_after_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && !issue_dbl) |=> issue_ready);
endmodule

// File: rtl/mpx_mul_core.sv
module mpx_mul_core #(
  parameter int unsigned OP_W = 32,
  localparam int unsigned RES_W = 2 * OP_W
) (
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  output logic [RES_W-1:0] p
);
  always_comb p = RES_W'(a) * RES_W'(b);
endmodule

// File: rtl/mpx_slot_pipe.sv
module mpx_slot_pipe
  import mpx_mul_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             prec_switch,
  input  logic             new_dbl,
  input  logic [RES_W-1:0] new_prod,
  output logic             out_vld,
  output logic [RES_W-1:0] out_prod
);
  slot_t slot_q [NSLOT];
  slot_t slot_d [NSLOT];
  slot_t mid_eff;
  logic  pop_end, pop_dbl;

  always_comb begin
    mid_eff     = slot_q[DBL_END];
    mid_eff.vld = slot_q[DBL_END].vld & ~prec_switch;
    pop_end     = slot_q[SGL_END].vld;
    pop_dbl     = ~slot_q[SGL_END].vld & mid_eff.vld & mid_eff.dbl;
    out_vld     = fire & (pop_end | pop_dbl);
    out_prod    = '0;
    if (fire && pop_end)      out_prod = slot_q[SGL_END].prod;
    else if (fire && pop_dbl) out_prod = mid_eff.prod;
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++) slot_d[i] = slot_q[i];
    if (fire) begin
      for (int i = NSLOT - 1; i > 0; i--) begin
        if (i - 1 == DBL_END) begin
          slot_d[i]     = mid_eff;
          slot_d[i].vld = mid_eff.vld & ~pop_dbl;
        end else begin
          slot_d[i] = slot_q[i-1];
        end
      end
      slot_d[0].vld  = 1'b1;
      slot_d[0].dbl  = new_dbl;
      slot_d[0].prod = new_prod;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (fire) begin
        slot_q[g] <= slot_d[g];
      end
    end

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(slot_q[g]));
  end

  p_head_filled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> slot_q[0].vld);
  p_out_needs_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (slot_q[SGL_END].vld || slot_q[DBL_END].vld));
  p_zero_when_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_prod == '0));
endmodule

// File: rtl/mpx_mul_seq.sv
module mpx_mul_seq
  import mpx_mul_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic             issue_dbl,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic             issue_ready,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data
);
  logic             fire, prec_switch;
  logic [RES_W-1:0] prod;

  mpx_issue_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_dbl   (issue_dbl),
    .issue_ready (issue_ready),
    .fire        (fire),
    .prec_switch (prec_switch)
  );

  mpx_mul_core #(.OP_W(OP_W)) u_core (
    .a (op_a),
    .b (op_b),
    .p (prod)
  );

  mpx_slot_pipe u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .prec_switch (prec_switch),
    .new_dbl     (issue_dbl),
    .new_prod    (prod),
    .out_vld     (res_valid),
    .out_prod    (res_data)
  );

  p_no_result_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_valid && issue_ready) |-> !res_valid);
endmodule

// File: tb/mpx_mul_seq_test.sv
module mpx_mul_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid, issue_dbl;
  logic [31:0] op_a, op_b;
  logic        issue_ready, res_valid;
  logic [63:0] res_data;

  int checks = 0;
  int errors = 0;

  // reference model slots: index 0 newest
  bit          mv [3];
  bit          md [3];
  logic [63:0] mp [3];
  bit          m_stall, m_seen, m_last;

  always #2 clk = ~clk;

  mpx_mul_seq uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_dbl(issue_dbl),
    .op_a(op_a), .op_b(op_b), .issue_ready(issue_ready),
    .res_valid(res_valid), .res_data(res_data)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 3; i++) begin
      mv[i] = 0; md[i] = 0; mp[i] = '0;
    end
    m_stall = 0; m_seen = 0; m_last = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    issue_valid = 0; issue_dbl = 0; op_a = '0; op_b = '0;
    rst_n = 0;
    #1;
    check("R1 ready in reset", issue_ready, 1);
    check("R1 no result in reset", res_valid, 0);
    @(negedge clk);
    rst_n = 1;
    model_clear();
  endtask

  // one cycle: attempt an issue, check ready and result against model
  task automatic issue(string req, bit dbl, logic [31:0] a, logic [31:0] b);
    bit          sw, mid_v, pe, pd, ev;
    logic [63:0] ep;
    @(negedge clk);
    issue_valid = 1; issue_dbl = dbl; op_a = a; op_b = b;
    #1;
    check({req, " ready"}, issue_ready, !m_stall);
    if (m_stall) begin
      check({req, " R4 ignored"}, res_valid, 0);
      m_stall = 0;
    end else begin
      sw    = m_seen && (dbl != m_last);
      mid_v = mv[1] && !sw;
      pe    = mv[2];
      pd    = !mv[2] && mid_v && md[1];
      ev    = pe || pd;
      ep    = pe ? mp[2] : (pd ? mp[1] : 64'd0);
      check({req, " valid"}, res_valid, ev);
      check({req, " data"}, res_data, ep);
      mv[2] = mid_v && !pd; md[2] = md[1]; mp[2] = mp[1];
      mv[1] = mv[0];        md[1] = md[0]; mp[1] = mp[0];
      mv[0] = 1; md[0] = dbl; mp[0] = 64'(a) * 64'(b);
      m_stall = dbl; m_seen = 1; m_last = dbl;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      issue_valid = 0;
      op_a = $urandom; op_b = $urandom;
      #1;
      check("R5 idle no result", res_valid, 0);
      check("R4 ready", issue_ready, !m_stall);
      m_stall = 0;
    end
  endtask

  task automatic t_reset();
    do_reset();
    issue("R1 first", 0, 3, 4);
    issue("R1 second", 0, 5, 6);
    issue("R1 third", 0, 7, 8);
    issue("R2 fourth", 0, 9, 10);
  endtask

  task automatic t_singles();
    do_reset();
    for (int i = 0; i < 8; i++)
      issue("R2 single stream", 0, 32'hFFFF_FFF0 + i, 32'h1000_0001 * (i + 1));
    issue("R2 max", 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int i = 0; i < 3; i++) issue("R2 flush", 0, 1, i);
  endtask

  task automatic t_doubles();
    do_reset();
    issue("R3 d1", 1, 100, 200);
    idle(1);
    issue("R3 d2", 1, 300, 400);
    idle(1);
    issue("R3 d3 returns d1", 1, 500, 600);
    issue("R4 attempt in stall", 1, 7, 7);
    issue("R3 d4 returns d2", 1, 32'hDEAD_BEEF, 32'h1234_5678);
    issue("R4 attempt in stall", 0, 9, 9);
    issue("R3 d5", 1, 2, 2);
  endtask

  task automatic t_idle();
    do_reset();
    issue("R5 s1", 0, 11, 12);
    idle(4);
    issue("R5 s2", 0, 13, 14);
    idle(3);
    issue("R5 s3", 0, 15, 16);
    issue("R5 s4 returns s1", 0, 17, 18);
  endtask

  task automatic t_switch_sd();
    do_reset();
    issue("R6 s1", 0, 21, 22);
    issue("R6 s2", 0, 23, 24);
    issue("R6 s3", 0, 25, 26);
    issue("R6 d1 switch", 1, 27, 28);
    idle(1);
    issue("R7 d2 empty", 1, 29, 30);
    idle(1);
    issue("R8 d3", 1, 31, 32);
    idle(1);
    issue("R8 d4", 1, 33, 34);
    idle(1);
    issue("R8 d5", 1, 35, 36);
  endtask

  task automatic t_switch_ds();
    do_reset();
    issue("R6 d1", 1, 41, 42);
    idle(1);
    issue("R6 d2", 1, 43, 44);
    idle(1);
    issue("R6 s1 switch", 0, 45, 46);
    issue("R8 s2", 0, 47, 48);
    issue("R8 s3", 0, 49, 50);
    issue("R6 d3 switch", 1, 51, 52);
    idle(1);
    issue("R8 d4", 1, 53, 54);
    issue("R6 s4 switch in stall", 0, 55, 56);
    issue("R6 s4 switch", 0, 55, 56);
    issue("R8 s5", 0, 57, 58);
    issue("R8 s6", 0, 59, 60);
    issue("R8 s7", 0, 61, 62);
  endtask

  task automatic t_mid_reset();
    do_reset();
    issue("R9 pre", 0, 71, 72);
    issue("R9 pre", 1, 73, 74);
    issue("R9 pre", 0, 75, 76);
    do_reset();
    issue("R9 post empty", 0, 1, 1);
    issue("R9 post empty", 0, 2, 2);
    issue("R9 post empty", 0, 3, 3);
    issue("R9 post first", 0, 4, 4);
  endtask

  initial begin
    issue_valid = 0; issue_dbl = 0; op_a = '0; op_b = '0; rst_n = 0;
    model_clear();
    t_reset();
    t_singles();
    t_doubles();
    t_idle();
    t_switch_sd();
    t_switch_ds();
    t_mid_reset();
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule